// File: doc/BRIEF.md
# Prioritized CAN Interrupt Code Encoder

This block sits beside a CAN controller and gathers its interrupt sources: transmit buffer completions, receive buffer arrivals, bus wake-up, and a group of error conditions (receive overrun, receive and transmit warning, receive and transmit error-passive, bus-off). The error conditions share one error flag. A separate status word reports which error conditions are active. Each source is a level held by its producer until that producer clears it.

Every cycle the block masks the sources with their enables. It picks the most urgent pending one and registers a small code for it, along with a combined interrupt request. Firmware reads the code and uses it as an index into a jump table. A 2-bit mode input selects the code layout:
- A legacy layout gives a 3-bit code with an individual enable per buffer.
- An extended layout gives a 5-bit code, with one enable for all transmit buffers and one for all receive buffers.
- A FIFO layout is the extended layout, except that every receive buffer reports the same code.

Top module: `can_irq_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, `int_code`, `int_req` and `err_status` become zero.
- R2: Urgency falls in this order: error, transmit buffers 0 upward, receive buffers 0 upward, wake-up. The code of a more urgent source is numerically lower, and when several enabled sources are pending the most urgent one is reported.
- R3: A pending source whose enable is clear does not affect `int_code`.
- R4: When the reported source clears, the next most urgent pending enabled source is reported on the following clock edge.
- R5: With `mode` = 0 (legacy) the codes are: error 1, transmit buffer i 2+i, receive buffer 0 5, receive buffer 1 6, wake-up 7. Bits 4:3 of `int_code` stay zero. Only receive buffers 0 and 1 take part, each gated by its own `rx_en` bit. `tx_grp_en` and `rx_grp_en` have no effect.
- R6: With `mode` = 1 (extended) the codes are: error 1, transmit buffer i 2+i, receive buffer j 16+j, wake-up 31. All transmit buffers are gated by `tx_grp_en` and all receive buffers by `rx_grp_en`. `tx_en` and `rx_en` have no effect.
- R7: With `mode` = 2 (FIFO) the extended rules apply, except that any enabled pending receive buffer reports code 16 (binary 10000).
- R8: The error source is pending when any bit of `err_src` is set, and it is gated by `err_en`. `err_status` shows the registered `err_src` vector whether or not the error is enabled.
- R9: When no enabled source is pending, `int_code` is 0 and `int_req` is low. `int_req` is high exactly when `int_code` is nonzero.
- R10: Outputs are registered. A change of inputs shows on the outputs after the next rising clock edge and not before.
- R11: `mode` = 3 behaves as the legacy layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Code layout: 0 legacy, 1 extended, 2 FIFO, 3 legacy |
| err_src | input | 6 | Error condition levels |
| err_en | input | 1 | Enable for the shared error source |
| tx_flag | input | 3 | Transmit buffer interrupt levels |
| tx_en | input | 3 | Per-buffer transmit enables (legacy) |
| tx_grp_en | input | 1 | Enable for all transmit buffers (extended, FIFO) |
| rx_flag | input | 8 | Receive buffer interrupt levels |
| rx_en | input | 2 | Per-buffer receive enables for buffers 0 and 1 (legacy) |
| rx_grp_en | input | 1 | Enable for all receive buffers (extended, FIFO) |
| wake_flag | input | 1 | Wake-up interrupt level |
| wake_en | input | 1 | Wake-up enable |
| int_code | output | 5 | Code of the most urgent pending enabled source |
| int_req | output | 1 | Combined interrupt request |
| err_status | output | 6 | Registered copy of the error condition levels |

## Verification
Every result of this block is due one rising edge after its stimulus, because one register stage lies between inputs and outputs. The bench changes inputs on a falling edge and samples outputs on the next falling edge, so each sample comes half a period after the edge that loads the result. The timing scenario also samples one nanosecond after the input change. That sample must still show the previous code, which shows that nothing reaches the outputs combinationally. Priority handover is checked by clearing one source per cycle and expecting the next code on the next falling edge.

// File: rtl/can_irq_pkg.sv
// Package: shared constants and types for the CAN interrupt code encoder.
// Assumes a 5-bit extended code; the legacy layout occupies its low 3 bits.
package can_irq_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_EXT    = 2'd1,
        MODE_FIFO   = 2'd2,
        MODE_RSVD   = 2'd3
    } irq_mode_e;

    localparam int CODE_W        = 5;
    localparam int CODE_ERR      = 1;
    localparam int CODE_TX_BASE  = 2;
    localparam int CODE_LEG_WAKE = 7;
    localparam int CODE_EXT_RX   = 16;
    localparam int CODE_EXT_WAKE = 31;
    localparam int LEG_RX_NUM    = 2;

    // Legacy and reserved mode share the 3-bit layout.
    function automatic logic is_legacy(input irq_mode_e m);
        return (m == MODE_LEGACY) || (m == MODE_RSVD);
    endfunction

endpackage

// File: rtl/irq_src_mask.sv
// Module: irq_src_mask
// Gates each interrupt source with the enable that the current mode selects
// and lays them out as a slot vector ordered by urgency (slot 0 most urgent):
// error, transmit buffers, receive buffers, wake-up.
// Assumes NRX >= LEG_RX_NUM; legacy mode only uses the first LEG_RX_NUM receive buffers.
module irq_src_mask
    import can_irq_pkg::*;
#(
    parameter int NTX   = 3,
    parameter int NRX   = 8,
    parameter int NERR  = 6,
    localparam int NSLOT = NTX + NRX + 2
) (
    input  irq_mode_e              mode,
    input  logic [NERR-1:0]        err_src,
    input  logic                   err_en,
    input  logic [NTX-1:0]         tx_flag,
    input  logic [NTX-1:0]         tx_en,
    input  logic                   tx_grp_en,
    input  logic [NRX-1:0]         rx_flag,
    input  logic [LEG_RX_NUM-1:0]  rx_en,
    input  logic                   rx_grp_en,
    input  logic                   wake_flag,
    input  logic                   wake_en,
    output logic [NSLOT-1:0]       req
);

    logic legacy;

    // Mode decode shared by all buffer slots.
    always_comb legacy = is_legacy(mode);

    // Shared error slot: any error condition raises it.
    always_comb req[0] = (|err_src) && err_en;

    // Transmit slots: per-buffer enable in legacy, group enable otherwise.
    for (genvar i = 0; i < NTX; i++) begin : g_tx
        always_comb req[1+i] = tx_flag[i] && (legacy ? tx_en[i] : tx_grp_en);
    end

    // Receive slots: only the first buffers exist in legacy layout.
    for (genvar j = 0; j < NRX; j++) begin : g_rx
        if (j < LEG_RX_NUM) begin : g_leg
            always_comb req[1+NTX+j] = rx_flag[j] && (legacy ? rx_en[j] : rx_grp_en);
        end else begin : g_ext
            always_comb req[1+NTX+j] = rx_flag[j] && !legacy && rx_grp_en;
        end
    end

    // Wake-up slot, least urgent.
    always_comb req[NSLOT-1] = wake_flag && wake_en;

endmodule

// File: rtl/irq_prio_pick.sv
// Module: irq_prio_pick
// Finds the lowest set bit of a request vector. Lower index means more urgent.
// Assumes IW is wide enough to hold N-1.
module irq_prio_pick #(
    parameter int N  = 13,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Scan from the top so that the lowest set index wins.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_code_map.sv
// Module: irq_code_map
// Turns the winning slot index into the code for the selected layout.
// Assumes NTX = 3 for the legacy layout, and NRX <= 15 so that extended
// receive codes stay below the wake-up code.
module irq_code_map
    import can_irq_pkg::*;
#(
    parameter int NTX   = 3,
    parameter int NRX   = 8,
    parameter int IW    = 4
) (
    input  irq_mode_e           mode,
    input  logic                found,
    input  logic [IW-1:0]       idx,
    output logic [CODE_W-1:0]   code
);

    int slot;
    int rxn;
    int val;

    // Slot to code translation per layout; zero when nothing is pending.
    always_comb begin
        slot = int'(idx);
        rxn  = slot - NTX - 1;
        val  = 0;
        if (found) begin
            if (slot == 0) begin
                val = CODE_ERR;
            end else if (slot <= NTX) begin
                val = CODE_TX_BASE + slot - 1;
            end else if (slot <= NTX + NRX) begin
                if (is_legacy(mode))       val = CODE_TX_BASE + NTX + rxn;
                else if (mode == MODE_FIFO) val = CODE_EXT_RX;
                else                        val = CODE_EXT_RX + rxn;
            end else begin
                val = is_legacy(mode) ? CODE_LEG_WAKE : CODE_EXT_WAKE;
            end
        end
        code = CODE_W'(val);
    end

endmodule

// File: rtl/can_irq_encoder.sv
// Module: can_irq_encoder (top)
// Masks the CAN interrupt sources, picks the most urgent one, maps it to the
// mode's code and registers the code, the combined request and the error status.
// Assumes the sources are levels held by their producers; reset is synchronous, active low.
module can_irq_encoder
    import can_irq_pkg::*;
#(
    parameter int NTX  = 3,
    parameter int NRX  = 8,
    parameter int NERR = 6,
    localparam int NSLOT = NTX + NRX + 2,
    localparam int IW    = $clog2(NSLOT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic [NERR-1:0]       err_src,
    input  logic                  err_en,
    input  logic [NTX-1:0]        tx_flag,
    input  logic [NTX-1:0]        tx_en,
    input  logic                  tx_grp_en,
    input  logic [NRX-1:0]        rx_flag,
    input  logic [LEG_RX_NUM-1:0] rx_en,
    input  logic                  rx_grp_en,
    input  logic                  wake_flag,
    input  logic                  wake_en,
    output logic [CODE_W-1:0]     int_code,
    output logic                  int_req,
    output logic [NERR-1:0]       err_status
);

    irq_mode_e         mode_e;
    logic [NSLOT-1:0]  req;
    logic              found;
    logic [IW-1:0]     idx;
    logic [CODE_W-1:0] code_nxt;

    // Cast the raw mode pins to the layout type.
    always_comb mode_e = irq_mode_e'(mode);

    irq_src_mask #(.NTX(NTX), .NRX(NRX), .NERR(NERR)) u_mask (
        .mode      (mode_e),
        .err_src   (err_src),
        .err_en    (err_en),
        .tx_flag   (tx_flag),
        .tx_en     (tx_en),
        .tx_grp_en (tx_grp_en),
        .rx_flag   (rx_flag),
        .rx_en     (rx_en),
        .rx_grp_en (rx_grp_en),
        .wake_flag (wake_flag),
        .wake_en   (wake_en),
        .req       (req)
    );

    irq_prio_pick #(.N(NSLOT), .IW(IW)) u_pick (
        .req   (req),
        .found (found),
        .idx   (idx)
    );

    irq_code_map #(.NTX(NTX), .NRX(NRX), .IW(IW)) u_map (
        .mode  (mode_e),
        .found (found),
        .idx   (idx),
        .code  (code_nxt)
    );

    // Output stage: code, request and error status change only on a clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_code   <= '0;
            int_req    <= 1'b0;
            err_status <= '0;
        end else begin
            int_code   <= code_nxt;
            int_req    <= found;
            err_status <= err_src;
        end
    end

endmodule

// File: rtl/can_irq_encoder_chk.sv
// Module: can_irq_encoder_chk
// Property checker bound to can_irq_encoder; observes ports only.
module can_irq_encoder_chk
    import can_irq_pkg::*;
#(
    parameter int NTX  = 3,
    parameter int NRX  = 8,
    parameter int NERR = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            mode,
    input logic [NERR-1:0]       err_src,
    input logic                  err_en,
    input logic [NTX-1:0]        tx_flag,
    input logic [NTX-1:0]        tx_en,
    input logic                  tx_grp_en,
    input logic [NRX-1:0]        rx_flag,
    input logic [LEG_RX_NUM-1:0] rx_en,
    input logic                  rx_grp_en,
    input logic                  wake_en,
    input logic [CODE_W-1:0]     int_code,
    input logic                  int_req
);

    // R9: request and nonzero code go together.
    a_r9_req_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        int_req == (int_code != '0));

    // R3: with every enable clear, nothing is reported.
    a_r3_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_en && tx_en == '0 && !tx_grp_en && rx_en == '0 && !rx_grp_en && !wake_en)
        |=> (int_code == '0 && !int_req));

    // R2, R8: an enabled error is always the most urgent.
    a_r8_error_first: assert property (@(posedge clk) disable iff (!rst_n)
        (err_en && (|err_src)) |=> (int_code == CODE_W'(CODE_ERR)));

    // R5: legacy layout never sets the upper code bits.
    a_r5_legacy_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEGACY) |=> (int_code[4:3] == 2'b00));

    // R7: FIFO receive collapses to the fixed code.
    a_r7_fifo_code: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FIFO && rx_grp_en && (|rx_flag)
         && !(err_en && (|err_src)) && !(tx_grp_en && (|tx_flag)))
        |=> (int_code == CODE_W'(CODE_EXT_RX)));

endmodule

bind can_irq_encoder can_irq_encoder_chk #(.NTX(NTX), .NRX(NRX), .NERR(NERR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .err_src   (err_src),
    .err_en    (err_en),
    .tx_flag   (tx_flag),
    .tx_en     (tx_en),
    .tx_grp_en (tx_grp_en),
    .rx_flag   (rx_flag),
    .rx_en     (rx_en),
    .rx_grp_en (rx_grp_en),
    .wake_en   (wake_en),
    .int_code  (int_code),
    .int_req   (int_req)
);

// File: tb/tb_can_irq_encoder.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module tb_can_irq_encoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic [5:0] err_src;
    logic       err_en;
    logic [2:0] tx_flag, tx_en;
    logic       tx_grp_en;
    logic [7:0] rx_flag;
    logic [1:0] rx_en;
    logic       rx_grp_en, wake_flag, wake_en;
    logic [4:0] int_code;
    logic       int_req;
    logic [5:0] err_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    can_irq_encoder dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .err_src(err_src), .err_en(err_en),
        .tx_flag(tx_flag), .tx_en(tx_en), .tx_grp_en(tx_grp_en),
        .rx_flag(rx_flag), .rx_en(rx_en), .rx_grp_en(rx_grp_en),
        .wake_flag(wake_flag), .wake_en(wake_en),
        .int_code(int_code), .int_req(int_req), .err_status(err_status)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_inputs();
        mode = 2'd0; err_src = '0; err_en = 0; tx_flag = '0; tx_en = '0; tx_grp_en = 0;
        rx_flag = '0; rx_en = '0; rx_grp_en = 0; wake_flag = 0; wake_en = 0;
    endtask

    // Inputs change just after a falling edge; result is due at the next falling edge.
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0;
        clear_inputs();
        err_src = 6'h3F; err_en = 1;
        repeat (3) @(negedge clk);
        check("R1 code", int_code, 0);
        check("R1 req", int_req, 0);
        check("R1 status", err_status, 0);
        clear_inputs();
        rst_n = 1;
        settle();
    endtask

    task automatic t_legacy_codes();
        clear_inputs();
        err_src = 6'b000001; err_en = 1; settle(); check("R5 error", int_code, 1);
        clear_inputs();
        for (int i = 0; i < 3; i++) begin
            clear_inputs(); tx_flag[i] = 1; tx_en[i] = 1; settle();
            check("R5 tx", int_code, 2 + i);
        end
        clear_inputs(); rx_flag[0] = 1; rx_en[0] = 1; settle(); check("R5 rx0", int_code, 5);
        clear_inputs(); rx_flag[1] = 1; rx_en[1] = 1; settle(); check("R5 rx1", int_code, 6);
        clear_inputs(); wake_flag = 1; wake_en = 1; settle(); check("R5 wake", int_code, 7);
        check("R9 req high", int_req, 1);
        clear_inputs(); rx_flag = 8'hFC; rx_grp_en = 1; tx_flag = 3'h7; tx_grp_en = 1; settle();
        check("R5 group enables ignored", int_code, 0);
    endtask

    task automatic t_priority();
        clear_inputs();
        err_src = 6'b010000; err_en = 1; tx_flag = 3'h7; tx_en = 3'h7;
        rx_flag = 8'h03; rx_en = 2'h3; wake_flag = 1; wake_en = 1;
        settle(); check("R2 all pending", int_code, 1);
        err_src = '0; settle(); check("R4 next tx0", int_code, 2);
        tx_flag[0] = 0; settle(); check("R4 next tx1", int_code, 3);
        tx_flag[1] = 0; settle(); check("R4 next tx2", int_code, 4);
        tx_flag[2] = 0; settle(); check("R4 next rx0", int_code, 5);
        rx_flag[0] = 0; settle(); check("R4 next rx1", int_code, 6);
        rx_flag[1] = 0; settle(); check("R4 next wake", int_code, 7);
        wake_flag = 0; settle(); check("R9 none code", int_code, 0);
        check("R9 none req", int_req, 0);
    endtask

    task automatic t_disabled();
        clear_inputs();
        err_src = 6'h3F; tx_flag = 3'h7; rx_flag = 8'hFF; wake_flag = 1;
        settle(); check("R3 all disabled code", int_code, 0);
        check("R3 all disabled req", int_req, 0);
        tx_en[2] = 1; settle(); check("R3 only tx2 enabled", int_code, 4);
    endtask

    task automatic t_extended();
        clear_inputs(); mode = 2'd1;
        tx_flag[1] = 1; tx_en = 3'h7; settle(); check("R6 per-buffer tx enable ignored", int_code, 0);
        tx_grp_en = 1; settle(); check("R6 tx1", int_code, 3);
        clear_inputs(); mode = 2'd1;
        rx_flag[5] = 1; rx_grp_en = 1; settle(); check("R6 rx5", int_code, 21);
        rx_flag[0] = 1; settle(); check("R6 rx0 wins", int_code, 16);
        clear_inputs(); mode = 2'd1;
        rx_flag[0] = 1; rx_en[0] = 1; settle(); check("R6 per-buffer rx enable ignored", int_code, 0);
        wake_flag = 1; wake_en = 1; settle(); check("R6 wake", int_code, 31);
    endtask

    task automatic t_fifo();
        clear_inputs(); mode = 2'd2; rx_grp_en = 1;
        rx_flag[6] = 1; settle(); check("R7 rx6", int_code, 16);
        rx_flag = 8'h01; settle(); check("R7 rx0", int_code, 16);
        tx_flag[2] = 1; tx_grp_en = 1; settle(); check("R7 tx2 over rx", int_code, 4);
    endtask

    task automatic t_error();
        clear_inputs();
        err_src = 6'b100100; err_en = 1; settle();
        check("R8 code", int_code, 1);
        check("R8 status", err_status, 6'b100100);
        err_en = 0; settle();
        check("R8 disabled code", int_code, 0);
        check("R8 status kept", err_status, 6'b100100);
    endtask

    task automatic t_reserved();
        clear_inputs(); mode = 2'd3;
        rx_flag[0] = 1; rx_en[0] = 1; settle(); check("R11 rx0", int_code, 5);
        clear_inputs(); mode = 2'd3;
        rx_flag[3] = 1; rx_grp_en = 1; settle(); check("R11 rx3 ignored", int_code, 0);
    endtask

    task automatic t_timing();
        clear_inputs(); settle();
        wake_flag = 1; wake_en = 1;
        #1; check("R10 not yet", int_code, 0);
        settle(); check("R10 after edge", int_code, 7);
    endtask

    initial begin
        clear_inputs();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_legacy_codes();
        t_priority();
        t_disabled();
        t_extended();
        t_fifo();
        t_error();
        t_reserved();
        t_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule